// File: doc/BRIEF.md
# Asynchronous Static RAM Word Controller

This block sits between a clocked host and an external asynchronous static RAM with a 19-bit word address, one shared 16-bit data bus and two active-low byte enables. Each host request moves one word, or one or both bytes of a word. The controller turns it into a strobe sequence on the RAM pins: one active-low chip select, one active-high chip select, write enable, output enable, two byte enables, outgoing data and a drive enable for the bus pads. The pad tristate buffers themselves sit outside the block.

Every phase length is a cycle count. Each count is found at elaboration by rounding a nanosecond minimum up to whole clock periods, with a floor of one cycle. At a 5 ns clock the counts are as follows. A write holds 2 setup cycles with the RAM selected and the lanes enabled, then 8 cycles with write enable low, then 1 hold cycle with data still driven. A read holds output enable low for 12 cycles and samples the bus on the last of them. After a read the bus is left undriven for 4 cycles, and after a write for 1 cycle, before the controller returns to idle.

The state machine has six states. ST_IDLE takes requests. A non-empty write moves to ST_WR_SETUP and a non-empty read moves to ST_RD_WAIT. ST_WR_SETUP moves to ST_WR_PULSE when its count ends, ST_WR_PULSE moves to ST_WR_HOLD, and ST_WR_HOLD moves to ST_GAP with the short count. ST_RD_WAIT moves to ST_GAP with the bus-release count and raises the response. ST_GAP returns to ST_IDLE. A request whose mask is empty is handled entirely in ST_IDLE.

Top module: `sram_async_ctrl`

## Requirements
- R1: In reset and right after it, req_ready is 1, mem_cs_n/mem_we_n/mem_oe_n/mem_lb_n/mem_ub_n are 1, and mem_cs, mem_dout_en and rsp_valid are 0.
- R2: Whenever the RAM is not selected (mem_cs_n high or mem_cs low), mem_we_n and mem_oe_n are high and mem_dout_en is low.
- R3: req_ready is high only in idle. A request is taken on a cycle with req_valid and req_ready both high. req_ready stays low while a non-empty request is in progress.
- R4: Mask bit 0 selects the low byte (data bits 7:0, mem_lb_n low). Mask bit 1 selects the high byte (bits 15:8, mem_ub_n low). A write changes only the bytes it selects.
- R5: A read gives one rsp_valid pulse. rsp_rdata carries the RAM data in the selected bytes and zero in the bytes not selected.
- R6: During a write, the chip selects and byte enables are active at least one cycle before mem_we_n falls and are still active in the cycle mem_we_n rises. mem_addr does not change while mem_we_n is low.
- R7: mem_we_n is low for at least ceil(max(40,25)/T) cycles. Select, lanes and address are valid for at least 50 ns up to the rise of mem_we_n. The whole selected write lasts at least 55 ns. Data is stable for at least 25 ns before mem_we_n rises.
- R8: A read keeps output enable, selects, lanes and address steady for at least ceil(55/T)+1 cycles and samples on the last of them.
- R9: mem_dout_en is high only while mem_we_n is low or in the single cycle after it rises, and never while mem_oe_n is low.
- R10: After mem_oe_n rises, mem_dout_en stays low for more than ceil(20/T) cycles. After mem_dout_en falls, at least one cycle passes before mem_oe_n falls.
- R11: A request with mask 00 produces no strobes and leaves req_ready high. A write with mask 00 changes nothing. A read with mask 00 returns rsp_valid in the next cycle with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_addr | input | 19 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | 2 | Byte select, bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, unselected bytes zero |
| mem_addr | output | 19 | RAM address |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_cs | output | 1 | RAM select, active high |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_lb_n | output | 1 | Low byte enable, active low |
| mem_ub_n | output | 1 | High byte enable, active low |
| mem_dout | output | 16 | Data toward RAM |
| mem_dout_en | output | 1 | Pad drive enable for mem_dout |
| mem_din | input | 16 | Data from RAM |

## Verification
The hardest case to provoke is a read that starts right after a write, or a write right after a read. This is where both sides could drive the bus or the RAM could still be releasing it. The bench issues each request in the first cycle req_ready allows, so every write-read and read-write pair runs at the shortest spacing the controller permits. A behavioural RAM model counts the cycles since output enable last rose and the cycles each strobe has been steady. It returns junk until the access time has passed, and junk in the bytes not selected, so an early sample or a missing byte mask shows up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_WAIT,
        ST_GAP
    } ctrl_state_e;

    // Round a nanosecond minimum up to whole clock periods, never below one.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // A phase of N cycles is loaded as N-1 and ends in the cycle that reads zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_len - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 2
) (
    input  logic                        active,
    input  logic [NUM_LANES-1:0]        lane_mask,
    input  logic [NUM_LANES*LANE_W-1:0] bus_in,
    output logic [NUM_LANES-1:0]        lane_en_n,
    output logic [NUM_LANES*LANE_W-1:0] bus_kept
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane_en_n[g] = !(active && lane_mask[g]);
        assign bus_kept[g*LANE_W +: LANE_W] =
            lane_mask[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS    = 5,
    parameter int ADDR_W    = 19,
    parameter int LANE_W    = 8,
    parameter int T_WP_NS   = 40,
    parameter int T_DW_NS   = 25,
    parameter int T_AW_NS   = 50,
    parameter int T_WC_NS   = 55,
    parameter int T_AA_NS   = 55,
    parameter int T_HZ_NS   = 20,
    parameter int RD_MARGIN = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_write,
    input  logic [1:0]          req_mask,
    input  logic [2*LANE_W-1:0] req_wdata,
    output logic                rsp_valid,
    output logic [2*LANE_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_cs_n,
    output logic                mem_cs,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic                mem_lb_n,
    output logic                mem_ub_n,
    output logic [2*LANE_W-1:0] mem_dout,
    output logic                mem_dout_en,
    input  logic [2*LANE_W-1:0] mem_din
);
    localparam int NUM_LANES    = 2;
    localparam int DATA_W       = NUM_LANES * LANE_W;

    // Phase lengths in clock cycles.
    localparam int WR_PULSE_CYC = max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS));
    localparam int WR_SETUP_CYC = max2(1, ns_to_cyc(T_AW_NS, CLK_NS) - WR_PULSE_CYC);
    localparam int WR_HOLD_CYC  = max2(1, ns_to_cyc(T_WC_NS, CLK_NS) - WR_SETUP_CYC - WR_PULSE_CYC);
    localparam int RD_CYC       = max2(ns_to_cyc(T_WC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)) + RD_MARGIN;
    localparam int TURN_RD_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int TURN_WR_CYC  = 1;
    localparam int MAX_CYC      = max2(max2(WR_PULSE_CYC, RD_CYC),
                                       max2(TURN_RD_CYC, max2(WR_SETUP_CYC, WR_HOLD_CYC)));
    localparam int CNT_W        = $clog2(MAX_CYC + 1);

    ctrl_state_e state_q, state_d;

    logic [ADDR_W-1:0]    addr_q;
    logic [NUM_LANES-1:0] mask_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [DATA_W-1:0]    rdata_q;
    logic                 rsp_q;

    logic                 tmr_load;
    logic [CNT_W-1:0]     tmr_len;
    logic                 tmr_done;

    logic                 accept;
    logic                 empty_req;
    logic                 selected;
    logic [NUM_LANES-1:0] lane_en_n;
    logic [DATA_W-1:0]    din_kept;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign empty_req = (req_mask == '0);

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_len (tmr_len),
        .done     (tmr_done)
    );

    sram_lane_map #(
        .LANE_W    (LANE_W),
        .NUM_LANES (NUM_LANES)
    ) lanes_i (
        .active    (selected),
        .lane_mask (mask_q),
        .bus_in    (mem_din),
        .lane_en_n (lane_en_n),
        .bus_kept  (din_kept)
    );

    // Next state and phase loading.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_len  = CNT_W'(1);
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !empty_req) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                        tmr_len = CNT_W'(WR_SETUP_CYC);
                    end else begin
                        state_d = ST_RD_WAIT;
                        tmr_len = CNT_W'(RD_CYC);
                    end
                end
            end
            ST_WR_SETUP: begin
                if (tmr_done) begin
                    state_d  = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(WR_PULSE_CYC);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    state_d  = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(WR_HOLD_CYC);
                end
            end
            ST_WR_HOLD: begin
                if (tmr_done) begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(TURN_WR_CYC);
                end
            end
            ST_RD_WAIT: begin
                if (tmr_done) begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(TURN_RD_CYC);
                end
            end
            ST_GAP: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture and read response.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            mask_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            rsp_q <= 1'b0;
            if (accept && !empty_req) begin
                addr_q  <= req_addr;
                mask_q  <= req_mask;
                wdata_q <= req_wdata;
            end
            if (accept && empty_req && !req_write) begin
                rsp_q   <= 1'b1;
                rdata_q <= '0;
            end
            if (state_q == ST_RD_WAIT && tmr_done) begin
                rsp_q   <= 1'b1;
                rdata_q <= din_kept;
            end
        end
    end

    // Strobe outputs decoded from the state.
    always_comb begin
        selected    = 1'b0;
        mem_we_n    = 1'b1;
        mem_oe_n    = 1'b1;
        mem_dout_en = 1'b0;
        req_ready   = 1'b0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_WR_SETUP: selected  = 1'b1;
            ST_WR_PULSE: begin
                selected    = 1'b1;
                mem_we_n    = 1'b0;
                mem_dout_en = 1'b1;
            end
            ST_WR_HOLD: begin
                selected    = 1'b1;
                mem_dout_en = 1'b1;
            end
            ST_RD_WAIT: begin
                selected = 1'b1;
                mem_oe_n = 1'b0;
            end
            ST_GAP:      ;
            default:     ;
        endcase
    end

    assign mem_cs_n  = !selected;
    assign mem_cs    = selected;
    assign mem_lb_n  = lane_en_n[0];
    assign mem_ub_n  = lane_en_n[1];
    assign mem_addr  = addr_q;
    assign mem_dout  = wdata_q;
    assign rsp_valid = rsp_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic              mem_dout_en
);
    // R2
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs_n || !mem_cs) |-> (mem_we_n && mem_oe_n && !mem_dout_en));

    // R3
    ready_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && !mem_cs));

    // R6
    we_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_cs && (!mem_lb_n || !mem_ub_n)));

    // R6
    we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_cs_n && mem_cs && (!mem_lb_n || !mem_ub_n)));

    // R6
    we_release_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_cs_n && mem_cs && (!mem_lb_n || !mem_ub_n)));

    // R6
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    // R9
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> mem_oe_n);

    // R10
    turn_wr_to_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> $past(!mem_dout_en));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W (ADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .mem_addr    (mem_addr),
    .mem_cs_n    (mem_cs_n),
    .mem_cs      (mem_cs),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_lb_n    (mem_lb_n),
    .mem_ub_n    (mem_ub_n),
    .mem_dout_en (mem_dout_en)
);

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;
    localparam int CLK_NS  = 5;
    localparam int AW      = 19;
    localparam int WP_MIN  = 40;
    localparam int DW_MIN  = 25;
    localparam int AW_MIN  = 50;
    localparam int WC_MIN  = 55;
    localparam int ACC_MIN = 55;
    localparam int HZ_CYC  = (20 + CLK_NS - 1) / CLK_NS;
    localparam int RD_MIN  = (ACC_MIN + CLK_NS - 1) / CLK_NS + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic req_write = 1'b0;
    logic [1:0] req_mask = 2'b00;
    logic [15:0] req_wdata = '0;
    logic rsp_valid;
    logic [15:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dout_en;
    logic [15:0] mem_dout;
    logic [15:0] mem_din = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sram_async_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_mask(req_mask), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
        .mem_ub_n(mem_ub_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", what, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old_w, input logic [15:0] new_w,
                                          input logic [1:0] m);
        return {m[1] ? new_w[15:8] : old_w[15:8], m[0] ? new_w[7:0] : old_w[7:0]};
    endfunction

    // Behavioural RAM: stores on the write-enable rise, returns junk until access time.
    logic [15:0] model_mem [int];
    logic [15:0] exp_mem [int];
    logic prev_sel, prev_we_low, prev_lb_n, prev_ub_n, prev_den, prev_rd, wrote;
    logic [AW-1:0] prev_addr;
    logic [15:0] prev_dout;
    int we_low_cnt, sel_cnt, be_cnt, addr_cnt, data_cnt, rd_cnt, oe_hi_cnt;
    int sel_total = 0;
    int last_rd_len = 0;

    always @(negedge clk) begin
        logic sel, rd_on, be_on;
        logic [15:0] cur;
        if (!rst_n) begin
            prev_sel = 0; prev_we_low = 0; prev_lb_n = 1; prev_ub_n = 1; prev_den = 0;
            prev_rd = 0; wrote = 0; prev_addr = '0; prev_dout = '0;
            we_low_cnt = 0; sel_cnt = 0; be_cnt = 0; addr_cnt = 0; data_cnt = 0;
            rd_cnt = 0; oe_hi_cnt = 1000;
            mem_din = 16'h0;
        end else begin
            sel   = !mem_cs_n && mem_cs;
            rd_on = sel && mem_we_n && !mem_oe_n;
            be_on = !mem_lb_n || !mem_ub_n;
            if (!mem_oe_n) oe_hi_cnt = 0;
            else if (oe_hi_cnt < 1000) oe_hi_cnt++;

            if (!sel) check("R2 strobes while deselected", {mem_we_n, mem_oe_n, mem_dout_en}, 3'b110);
            if (mem_dout_en) begin
                check("R9 drive with output enable low", mem_oe_n, 1);
                check("R9 drive outside write", !mem_we_n || prev_we_low, 1);
                check("R10 drive before bus release", oe_hi_cnt > HZ_CYC, 1);
            end
            if (!mem_we_n && !prev_we_low)
                check("R6 select and lanes before WE fall", prev_sel && (!prev_lb_n || !prev_ub_n), 1);
            if (mem_we_n && prev_we_low) begin
                check("R6 still selected at WE rise", sel && be_on, 1);
                check("R7 WE low width", we_low_cnt * CLK_NS >= WP_MIN, 1);
                check("R7 select to end of write", sel_cnt * CLK_NS >= AW_MIN, 1);
                check("R7 lanes to end of write", be_cnt * CLK_NS >= AW_MIN, 1);
                check("R7 address to end of write", addr_cnt * CLK_NS >= AW_MIN, 1);
                check("R7 data setup", data_cnt * CLK_NS >= DW_MIN, 1);
                cur = model_mem.exists(int'(prev_addr)) ? model_mem[int'(prev_addr)] : 16'h0;
                model_mem[int'(prev_addr)] = merge(cur, prev_dout, {!prev_ub_n, !prev_lb_n});
                wrote = 1;
            end
            if (prev_sel && !sel && wrote) begin
                check("R7 write cycle length", sel_cnt * CLK_NS >= WC_MIN, 1);
                wrote = 0;
            end
            if (prev_rd && !rd_on) last_rd_len = rd_cnt;

            we_low_cnt = !mem_we_n ? we_low_cnt + 1 : 0;
            sel_cnt    = sel ? sel_cnt + 1 : 0;
            be_cnt     = (sel && be_on) ?
                         ((prev_sel && mem_lb_n == prev_lb_n && mem_ub_n == prev_ub_n) ? be_cnt + 1 : 1) : 0;
            if (mem_addr != prev_addr) addr_cnt = 1;
            else if (addr_cnt < 1000) addr_cnt++;
            data_cnt   = mem_dout_en ? ((prev_den && mem_dout == prev_dout) ? data_cnt + 1 : 1) : 0;
            rd_cnt     = rd_on ? ((prev_rd && mem_addr == prev_addr && mem_lb_n == prev_lb_n &&
                                   mem_ub_n == prev_ub_n) ? rd_cnt + 1 : 1) : 0;
            if (sel) sel_total++;

            if (rd_on && rd_cnt * CLK_NS >= ACC_MIN) begin
                cur = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 16'h0;
                mem_din = {mem_ub_n ? 8'hC3 : cur[15:8], mem_lb_n ? 8'h3C : cur[7:0]};
            end else begin
                mem_din = 16'hE1E1;
            end

            prev_sel = sel; prev_we_low = !mem_we_n; prev_lb_n = mem_lb_n; prev_ub_n = mem_ub_n;
            prev_den = mem_dout_en; prev_rd = rd_on; prev_addr = mem_addr; prev_dout = mem_dout;
        end
    end

    task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic [1:0] m,
                         input logic [15:0] d, output logic [15:0] rd);
        int w;
        rd = 16'h0;
        w = 0;
        while (!req_ready && w < 1000) begin
            @(negedge clk);
            w++;
        end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_mask = m; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (m != 2'b00) check("R3 ready low while busy", req_ready, 0);
        else            check("R11 ready stays high on empty mask", req_ready, 1);
        if (wr) begin
            if (m != 2'b00)
                exp_mem[int'(a)] = merge(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0, d, m);
        end else if (m == 2'b00) begin
            check("R11 empty read answers next cycle", rsp_valid, 1);
            rd = rsp_rdata;
        end else begin
            w = 0;
            while (!rsp_valid && w < 100) begin
                @(negedge clk);
                w++;
            end
            check("R5 read response present", rsp_valid, 1);
            rd = rsp_rdata;
        end
    endtask

    function automatic logic [15:0] expect_rd(input logic [AW-1:0] a, input logic [1:0] m);
        logic [15:0] e;
        e = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0;
        return {m[1] ? e[15:8] : 8'h00, m[0] ? e[7:0] : 8'h00};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements) act=timeout exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic [AW-1:0] a;
        logic [15:0] p0;
        int snap;

        repeat (5) @(negedge clk);
        check("R1 outputs during reset",
              {req_ready, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dout_en, rsp_valid},
              9'b1_1_0_1_1_1_1_0_0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset",
              {req_ready, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dout_en, rsp_valid},
              9'b1_1_0_1_1_1_1_0_0);

        for (int i = 0; i < 12; i++) begin
            if (i == 0)       a = '0;
            else if (i == 11) a = {AW{1'b1}};
            else              a = AW'(i * 42407 + i * i * 7);
            p0 = {a[7:0] ^ 8'h3C, a[15:8] + 8'(i)};

            do_op(1'b1, a, 2'b11, p0, rd);
            do_op(1'b0, a, 2'b11, 16'h0, rd);
            check("R5 full word read-back", rd, expect_rd(a, 2'b11));

            for (int m = 1; m < 4; m++) begin
                do_op(1'b1, a, 2'(m), ~p0 + 16'(m * 16'h1111), rd);
                for (int r = 1; r < 4; r++) begin
                    do_op(1'b0, a, 2'(r), 16'h0, rd);
                    check("R4 byte-masked write, masked read", rd, expect_rd(a, 2'(r)));
                end
            end
            @(negedge clk);
            check("R8 read held long enough", last_rd_len >= RD_MIN, 1);

            snap = sel_total;
            do_op(1'b1, a, 2'b00, 16'hFFFF, rd);
            repeat (3) @(negedge clk);
            check("R11 empty write makes no strobes", sel_total, snap);
            do_op(1'b0, a, 2'b00, 16'h0, rd);
            check("R11 empty read returns zero", rd, 16'h0);
            check("R11 empty read makes no strobes", sel_total, snap);
            do_op(1'b0, a, 2'b11, 16'h0, rd);
            check("R11 empty write left word intact", rd, expect_rd(a, 2'b11));
        end

        repeat (10) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule